// File: doc/BRIEF.md
# Edge Interrupt Acknowledge Tracker

This block follows a single edge-triggered interrupt line from the moment it is delivered until every CPU that took it has signalled end-of-interrupt (EOI). When a delivery completes, the block records which CPUs accepted it in an outstanding-acknowledge bitmap and loads a counter with the number of acceptances. Each EOI pulse from a CPU whose bit is set clears that bit and lowers the counter. While the counter is non-zero, a new request on the line is refused and flagged as coalesced, so the system can tell that an edge was merged into one still in flight.

The tracker can be rebuilt from the pending-EOI status that each CPU reports for the tracked vector. A resync walks the CPUs one per cycle and raises a busy flag. Only CPUs that match the line's destination are compared, and a bit and the counter change only where the reported status disagrees with the stored bit. A full resync first zeroes the bitmap and the counter. If an EOI or a resync step would take the counter below zero, the block starts a full rebuild by itself. EOI pulses that arrive during a walk are held and applied once it ends.

Top module: `eoi_coalesce_tracker`

## Requirements
- R1: After reset the pending count is 0, the busy flag is low, and a line request is forwarded, not coalesced.
- R2: An accepted delivery records its destination map. With `dlv_ok` high it loads the count with `dlv_count` clipped to NUM_CPUS. With `dlv_ok` low it loads 0. The new count is visible after the accepting clock edge.
- R3: A delivery is accepted only while the count is 0, no walk is running and no resync starts in the same cycle. Otherwise `dlv_err` is high in that cycle and the bitmap and count are unchanged.
- R4: An EOI pulse is captured at one clock edge and applied at the next. If the CPU's bit is set and the count is non-zero, the bit clears and the count drops by one. Several EOIs are applied one per cycle.
- R5: An EOI from a CPU whose bit is clear changes neither the count nor the busy flag.
- R6: A line request is reported on `line_coalesced` while the count is non-zero or a walk is running. Otherwise it is reported on `line_fwd`. This is combinational, and exactly one of the two is high while the request is high.
- R7: A resync raises busy for exactly NUM_CPUS cycles and visits CPU indices 0 upward. For a CPU with its `cpu_match` bit set, a pending-but-clear bit is set with the count raised by one, and a set-but-not-pending bit is cleared with the count lowered by one. CPUs with `cpu_match` clear keep their bit.
- R8: A full resync (`resync_full` high at start) zeroes the bitmap and count first. It ends with a count equal to the number of CPUs that are both pending and matching.
- R9: When an EOI hits a set bit while the count is 0, or a walk step would clear a bit with the count at 0, the block zeroes the state and starts a full walk from CPU 0.
- R10: EOIs that arrive while busy leave the count unchanged until the walk ends. They are then applied from the first cycle after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | Delivery result present this cycle |
| dlv_ok | input | 1 | Delivery succeeded (low: failed or negative result) |
| dlv_count | input | CNT_W | Number of CPUs that accepted the delivery |
| dlv_map | input | NUM_CPUS | CPUs that accepted the delivery |
| dlv_err | output | 1 | Delivery refused this cycle |
| eoi_valid | input | 1 | EOI pulse from one CPU |
| eoi_cpu | input | IDX_W | Index of the CPU sending EOI |
| line_req | input | 1 | New assertion of the tracked line |
| line_coalesced | output | 1 | Request refused as coalesced |
| line_fwd | output | 1 | Request may be delivered |
| resync_req | input | 1 | Start a resync walk |
| resync_full | input | 1 | Zero the state before walking |
| cpu_pending | input | NUM_CPUS | Per-CPU pending-EOI status for the tracked vector |
| cpu_match | input | NUM_CPUS | Per-CPU destination match of the tracked line |
| resync_busy | output | 1 | Walk in progress |
| pending_cnt | output | CNT_W | Outstanding acknowledge count |

## Verification
A wrong bitmap bit stays hidden until the CPU it belongs to sends EOI. It then shows two cycles after the pulse, either as a count that fails to drop or as a spurious rebuild with busy rising. A wrong count shows at once on `line_coalesced` and `dlv_err`, which are combinational from it. A walker that visits the wrong CPU or runs for the wrong number of cycles shows in the length of the busy window and in the count left after a full resync. The sweep over every pending and match pattern exposes such a walker within one walk.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/eoi_walk_seq.sv
module eoi_walk_seq
  import eoi_trk_pkg::*;
#(
  parameter int NUM_CPUS = 16,
  localparam int IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  walk_state_e state;

  assign busy = (state == WALK_RUN);
  assign last = busy && (idx == IDX_W'(NUM_CPUS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= WALK_IDLE;
      idx   <= '0;
    end else if (kick) begin
      state <= WALK_RUN;
      idx   <= '0;
    end else if (busy) begin
      if (last) begin
        state <= WALK_IDLE;
        idx   <= '0;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/eoi_hold_set.sv
module eoi_hold_set #(
  parameter int NUM_CPUS = 16,
  localparam int IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  input  logic [IDX_W-1:0] pop_idx,
  output logic             any,
  output logic [IDX_W-1:0] sel
);
  logic [NUM_CPUS-1:0] held;
  logic [NUM_CPUS-1:0] push_mask;
  logic [NUM_CPUS-1:0] pop_mask;

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_mask
    assign push_mask[g] = push && (push_idx == IDX_W'(g));
    assign pop_mask[g]  = pop  && (pop_idx  == IDX_W'(g));
  end

  assign any = |held;

  always_comb begin
    sel = '0;
    for (int i = NUM_CPUS - 1; i >= 0; i--) begin
      if (held[i]) sel = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held <= '0;
    else        held <= (held & ~pop_mask) | push_mask;
  end
endmodule

// File: rtl/eoi_coalesce_tracker.sv
module eoi_coalesce_tracker
  import eoi_trk_pkg::*;
#(
  parameter int NUM_CPUS = 16,
  localparam int IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int CNT_W = $clog2(2 * NUM_CPUS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dlv_valid,
  input  logic                dlv_ok,
  input  logic [CNT_W-1:0]    dlv_count,
  input  logic [NUM_CPUS-1:0] dlv_map,
  output logic                dlv_err,
  input  logic                eoi_valid,
  input  logic [IDX_W-1:0]    eoi_cpu,
  input  logic                line_req,
  output logic                line_coalesced,
  output logic                line_fwd,
  input  logic                resync_req,
  input  logic                resync_full,
  input  logic [NUM_CPUS-1:0] cpu_pending,
  input  logic [NUM_CPUS-1:0] cpu_match,
  output logic                resync_busy,
  output logic [CNT_W-1:0]    pending_cnt
);
  function automatic logic [CNT_W-1:0] load_value(input logic ok, input logic [CNT_W-1:0] n);
    if (!ok) return '0;
    if (int'(n) > NUM_CPUS) return CNT_W'(NUM_CPUS);
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_up(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_down(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  logic [NUM_CPUS-1:0] ack_map;
  logic [CNT_W-1:0]    cnt;
  logic                cnt_zero;

  logic                busy;
  logic [IDX_W-1:0]    walk_idx;
  logic                walk_last;
  logic                walk_kick;

  logic                hold_any;
  logic [IDX_W-1:0]    hold_sel;
  logic                eoi_pop;

  logic                start;
  logic                walk_diff, walk_set, walk_clr, walk_under;
  logic                dlv_accept;
  logic [CNT_W-1:0]    dlv_load;
  logic                eoi_hit, eoi_clr, eoi_under;
  logic                underflow, zero_now;

  eoi_walk_seq #(.NUM_CPUS(NUM_CPUS)) u_walk (
    .clk  (clk),
    .rst_n(rst_n),
    .kick (walk_kick),
    .busy (busy),
    .idx  (walk_idx),
    .last (walk_last)
  );

  eoi_hold_set #(.NUM_CPUS(NUM_CPUS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (eoi_valid),
    .push_idx(eoi_cpu),
    .pop     (eoi_pop),
    .pop_idx (hold_sel),
    .any     (hold_any),
    .sel     (hold_sel)
  );

  assign cnt_zero   = (cnt == '0);
  assign start      = resync_req && !busy;

  assign walk_diff  = busy && cpu_match[walk_idx] && (cpu_pending[walk_idx] != ack_map[walk_idx]);
  assign walk_set   = walk_diff && cpu_pending[walk_idx];
  assign walk_clr   = walk_diff && !cpu_pending[walk_idx] && !cnt_zero;
  assign walk_under = walk_diff && !cpu_pending[walk_idx] && cnt_zero;

  assign dlv_accept = dlv_valid && !busy && !start && cnt_zero;
  assign dlv_err    = dlv_valid && !dlv_accept;
  assign dlv_load   = load_value(dlv_ok, dlv_count);

  assign eoi_pop    = !busy && !start && !dlv_accept && hold_any;
  assign eoi_hit    = eoi_pop && ack_map[hold_sel];
  assign eoi_clr    = eoi_hit && !cnt_zero;
  assign eoi_under  = eoi_hit && cnt_zero;

  assign underflow  = walk_under || eoi_under;
  assign zero_now   = underflow || (start && resync_full);
  assign walk_kick  = start || underflow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_map <= '0;
      cnt     <= '0;
    end else if (zero_now) begin
      ack_map <= '0;
      cnt     <= '0;
    end else if (walk_set) begin
      ack_map[walk_idx] <= 1'b1;
      cnt               <= cnt_up(cnt);
    end else if (walk_clr) begin
      ack_map[walk_idx] <= 1'b0;
      cnt               <= cnt_down(cnt);
    end else if (dlv_accept) begin
      ack_map <= dlv_map;
      cnt     <= dlv_load;
    end else if (eoi_clr) begin
      ack_map[hold_sel] <= 1'b0;
      cnt               <= cnt_down(cnt);
    end
  end

  assign line_coalesced = line_req && (!cnt_zero || busy);
  assign line_fwd       = line_req && cnt_zero && !busy;
  assign resync_busy    = busy;
  assign pending_cnt    = cnt;
endmodule

// File: rtl/eoi_coalesce_tracker_chk.sv
module eoi_coalesce_tracker_chk #(
  parameter int NUM_CPUS = 16,
  localparam int CNT_W = $clog2(2 * NUM_CPUS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dlv_accept,
  input logic [CNT_W-1:0] dlv_load,
  input logic             dlv_err,
  input logic             resync_req,
  input logic             resync_busy,
  input logic [CNT_W-1:0] pending_cnt,
  input logic             line_req,
  input logic             line_coalesced,
  input logic             line_fwd,
  input logic             underflow,
  input logic             zero_now,
  input logic             walk_last,
  input logic             eoi_pop
);
  assert_load_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_accept |=> (pending_cnt == $past(dlv_load)));

  assert_refuse_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_err |-> (pending_cnt != '0 || resync_busy || resync_req));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_now && !dlv_accept) |=>
      ((int'(pending_cnt) <= int'($past(pending_cnt)) + 1) &&
       (int'(pending_cnt) + 1 >= int'($past(pending_cnt)))));

  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_req |-> (line_coalesced != line_fwd));

  assert_walk_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resync_busy) |-> $past(walk_last));

  assert_rebuild_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (resync_busy && pending_cnt == '0));

  assert_hold_during_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resync_busy |-> !eoi_pop);
endmodule

bind eoi_coalesce_tracker eoi_coalesce_tracker_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dlv_accept    (dlv_accept),
  .dlv_load      (dlv_load),
  .dlv_err       (dlv_err),
  .resync_req    (resync_req),
  .resync_busy   (resync_busy),
  .pending_cnt   (pending_cnt),
  .line_req      (line_req),
  .line_coalesced(line_coalesced),
  .line_fwd      (line_fwd),
  .underflow     (underflow),
  .zero_now      (zero_now),
  .walk_last     (walk_last),
  .eoi_pop       (eoi_pop)
);

// File: tb/test_eoi_coalesce_tracker.sv
module test_eoi_coalesce_tracker;
  localparam int N     = 4;
  localparam int IDX_W = $clog2(N);
  localparam int CNT_W = $clog2(2 * N + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dlv_valid = 1'b0, dlv_ok = 1'b0;
  logic [CNT_W-1:0] dlv_count = '0;
  logic [N-1:0]     dlv_map = '0;
  logic             dlv_err;
  logic             eoi_valid = 1'b0;
  logic [IDX_W-1:0] eoi_cpu = '0;
  logic             line_req = 1'b0;
  logic             line_coalesced, line_fwd;
  logic             resync_req = 1'b0, resync_full = 1'b0;
  logic [N-1:0]     cpu_pending = '0, cpu_match = '0;
  logic             resync_busy;
  logic [CNT_W-1:0] pending_cnt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  eoi_coalesce_tracker #(.NUM_CPUS(N)) i_eoi_coalesce_tracker (.*);

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic deliver(input logic [N-1:0] m, input logic ok, input int n, input int exp_err, input string rq);
    dlv_valid = 1'b1; dlv_ok = ok; dlv_map = m; dlv_count = CNT_W'(n);
    #1 chk(rq, int'(dlv_err), exp_err);
    @(negedge clk);
    dlv_valid = 1'b0;
  endtask

  task automatic eoi(input int cpu);
    eoi_valid = 1'b1; eoi_cpu = IDX_W'(cpu);
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic resync_go(input logic full, input logic [N-1:0] p, input logic [N-1:0] m);
    cpu_pending = p; cpu_match = m; resync_full = full; resync_req = 1'b1;
    @(negedge clk);
    resync_req = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (resync_busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic int ones(input logic [N-1:0] v);
    int s = 0;
    for (int i = 0; i < N; i++) s += int'(v[i]);
    return s;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(pending_cnt), 0);
    chk("R1 busy", int'(resync_busy), 0);
    line_req = 1'b1;
    #1 chk("R1 fwd", int'(line_fwd), 1);
    chk("R6 coalesced idle", int'(line_coalesced), 0);
    line_req = 1'b0;

    // R2 delivery loads count
    deliver(4'b1011, 1'b1, 3, 0, "R2 accept");
    chk("R2 count", int'(pending_cnt), 3);
    line_req = 1'b1;
    #1 chk("R6 coalesced", int'(line_coalesced), 1);
    chk("R6 no fwd", int'(line_fwd), 0);
    line_req = 1'b0;

    // R3 refused delivery
    deliver(4'b1111, 1'b1, 4, 1, "R3 err flag");
    chk("R3 count kept", int'(pending_cnt), 3);

    // R5 EOI on clear bit
    eoi(2);
    @(negedge clk);
    chk("R5 count", int'(pending_cnt), 3);
    chk("R5 busy", int'(resync_busy), 0);

    // R4 EOI on set bit, then two back to back
    eoi(1);
    @(negedge clk);
    chk("R4 single", int'(pending_cnt), 2);
    eoi(0);
    eoi(3);
    chk("R4 first of two", int'(pending_cnt), 1);
    @(negedge clk);
    chk("R4 second of two", int'(pending_cnt), 0);
    line_req = 1'b1;
    #1 chk("R6 fwd after acks", int'(line_fwd), 1);
    line_req = 1'b0;

    // R2 failed delivery records map with zero count; R9 underflow rebuild
    cpu_pending = 4'b0001; cpu_match = 4'b1111;
    deliver(4'b0110, 1'b0, 2, 0, "R2 failed accept");
    chk("R2 failed count", int'(pending_cnt), 0);
    eoi(1);
    @(negedge clk);
    chk("R9 busy after underflow", int'(resync_busy), 1);
    chk("R9 zeroed", int'(pending_cnt), 0);
    wait_idle(n);
    chk("R9 rebuilt count", int'(pending_cnt), 1);
    eoi(0);
    @(negedge clk);
    chk("R4 after rebuild", int'(pending_cnt), 0);

    // R8/R7 full resync sweep over every pending and match pattern
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        resync_go(1'b1, N'(p), N'(m));
        wait_idle(n);
        chk("R7 busy length", n, N);
        chk("R8 full count", int'(pending_cnt), ones(N'(p) & N'(m)));
      end
    end

    // R7 partial resync: only matched CPUs compared, map now 1111 count 4
    resync_go(1'b0, 4'b0101, 4'b0011);
    wait_idle(n);
    chk("R7 partial count", int'(pending_cnt), 3);
    eoi(1);
    @(negedge clk);
    chk("R7 cleared bit1", int'(pending_cnt), 3);
    eoi(3);
    @(negedge clk);
    chk("R7 kept bit3", int'(pending_cnt), 2);
    eoi(2);
    @(negedge clk);
    chk("R7 kept bit2", int'(pending_cnt), 1);
    eoi(1);
    @(negedge clk);
    // map is now {0}, count 1; add bit 3 back through a partial resync
    resync_go(1'b0, 4'b1000, 4'b1000);
    wait_idle(n);
    chk("R7 partial set", int'(pending_cnt), 2);

    // R10 EOI during walk is held; R3 delivery refused while busy
    resync_go(1'b0, 4'b0000, 4'b0000);
    eoi(0);
    chk("R10 held while busy", int'(pending_cnt), 2);
    deliver(4'b0001, 1'b1, 1, 1, "R3 err while busy");
    wait_idle(n);
    chk("R10 not yet applied", int'(pending_cnt), 2);
    @(negedge clk);
    chk("R10 applied after walk", int'(pending_cnt), 1);

    // R9 underflow inside a partial walk restarts as full walk
    eoi(3);
    @(negedge clk);
    chk("R4 to zero", int'(pending_cnt), 0);
    deliver(4'b0001, 1'b0, 0, 0, "R2 failed map only");
    resync_go(1'b0, 4'b0000, 4'b0001);
    wait_idle(n);
    chk("R9 restarted walk length", n, N + 1);
    chk("R9 count after restart", int'(pending_cnt), 0);
    eoi(0);
    @(negedge clk);
    chk("R9 map cleared busy", int'(resync_busy), 0);
    chk("R9 map cleared count", int'(pending_cnt), 0);

    // R2 clipping of an oversized count
    deliver(4'b1111, 1'b1, 15, 0, "R2 clip accept");
    chk("R2 clipped count", int'(pending_cnt), N);

    finish_run();
  end
endmodule